// File: doc/BRIEF.md
# Sub-Register Addressed Register File

This block holds eight 32-bit general registers. Each access selects a register code, and the narrow views of that register, from a small set of qualifiers. These are a 3-bit register code, a flag that says whether the instruction carries a width bit, the width bit itself, and the current operation size (16 or 32 bits). From these the block picks a low-byte, high-byte, 16-bit or 32-bit view of one register.

There are two combinational read ports and one clocked write port. Both read ports share the operation-size input. A read returns the selected view zero-extended to 32 bits. A write replaces only the bits of the selected view and keeps every other bit of that register. In the byte views, codes 4 to 7 do not reach registers 4 to 7. They select bits 15:8 of registers 0 to 3.

Top module: `gpr_view_file`

## Requirements
- R1: While `rst_n` is low, all eight registers are zero. After reset is released, every read view returns 0 until a write occurs.
- R2: In the 16-bit and 32-bit views, code value n (0 to 7) addresses register n. The registers are the accumulator, count, data, base, stack pointer, base pointer, source index and destination index, in that order.
- R3: When `*_has_w` is 0, the view is bits 15:0 if `op32` is 0 and bits 31:0 if `op32` is 1.
- R4: When `*_has_w` is 1 and `*_w` is 0, codes 0 to 3 select bits 7:0 of registers 0 to 3.
- R5: When `*_has_w` is 1 and `*_w` is 0, codes 4 to 7 select bits 15:8 of registers code-4, that is registers 0 to 3.
- R6: When `*_has_w` is 1 and `*_w` is 1, the view is the same as with no width bit: 16 bits if `op32` is 0, 32 bits if `op32` is 1.
- R7: A read returns the selected view in the low bits of its 32-bit output, with every bit above the view width zero.
- R8: A write of a byte or 16-bit view takes its value from the low 8 or 16 bits of `wr_data` and leaves every other bit of the target register unchanged. A write to a high-byte view stores `wr_data[7:0]` into bits 15:8.
- R9: A write takes effect only at a rising clock edge with `wr_en` high. With `wr_en` low, no register changes.
- R10: A read of a view that is being written in the same cycle returns the value from before the write. The new value is visible after the edge.
- R11: The two read ports are independent. Each can select any view at the same time as the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op32 | input | 1 | Operation size: 0 = 16-bit, 1 = 32-bit |
| rd0_code | input | 3 | Register code for read port 0 |
| rd0_has_w | input | 1 | Read port 0: width bit present |
| rd0_w | input | 1 | Read port 0: width bit |
| rd0_data | output | 32 | Read port 0 zero-extended view |
| rd1_code | input | 3 | Register code for read port 1 |
| rd1_has_w | input | 1 | Read port 1: width bit present |
| rd1_w | input | 1 | Read port 1: width bit |
| rd1_data | output | 32 | Read port 1 zero-extended view |
| wr_en | input | 1 | Write enable |
| wr_code | input | 3 | Register code for the write |
| wr_has_w | input | 1 | Write: width bit present |
| wr_w | input | 1 | Write: width bit |
| wr_data | input | 32 | Write value, low-aligned to the view |

## Verification
The main target is the high-byte aliasing. If a design routed byte codes 4 to 7 to registers 4 to 7, the stack-pointer to destination-index registers would change on byte writes. Reads of bits 15:8 of registers 0 to 3 would then come back stale. Narrow writes are checked against full-width readback. A design that wrote the whole register, or cleared the upper bits, would lose the bits around the view. The bench also reads a view in the same cycle it is written, which exposes a bypass. A full sweep of code, width-bit and size combinations on both ports catches a mis-decoded view, or a read that is not zero-extended.

// File: rtl/gprv_pkg.sv
package gprv_pkg;
    typedef enum logic [1:0] {
        VW_LO8 = 2'd0,
        VW_HI8 = 2'd1,
        VW_W16 = 2'd2,
        VW_W32 = 2'd3
    } view_e;
endpackage

// File: rtl/gprv_decode.sv
module gprv_decode
    import gprv_pkg::*;
#(
    parameter int CODE_W = 3,
    localparam int IDX_W = CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              has_w,
    input  logic              w,
    input  logic              op32,
    output logic [IDX_W-1:0]  idx,
    output view_e             view
);
    // A narrow byte selection folds the top code bit into a low/high choice.
    always_comb begin
        if (has_w && !w) begin
            idx  = {1'b0, code[CODE_W-2:0]};
            view = code[CODE_W-1] ? VW_HI8 : VW_LO8;
        end else begin
            idx  = code;
            view = op32 ? VW_W32 : VW_W16;
        end
    end
endmodule

// File: rtl/gprv_extract.sv
module gprv_extract
    import gprv_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTE_W = 8,
    localparam int HALF_W = 16
) (
    input  logic [DATA_W-1:0] word,
    input  view_e             view,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        data = '0;
        unique case (view)
            VW_LO8: data[BYTE_W-1:0] = word[BYTE_W-1:0];
            VW_HI8: data[BYTE_W-1:0] = word[HALF_W-1:BYTE_W];
            VW_W16: data[HALF_W-1:0] = word[HALF_W-1:0];
            VW_W32: data             = word;
            default: data            = '0;
        endcase
    end
endmodule

// File: rtl/gprv_merge.sv
module gprv_merge
    import gprv_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTE_W = 8,
    localparam int HALF_W = 16
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] wdata,
    input  view_e             view,
    output logic [DATA_W-1:0] new_word
);
    // Only the bits of the selected view are replaced.
    always_comb begin
        new_word = old_word;
        unique case (view)
            VW_LO8: new_word[BYTE_W-1:0]      = wdata[BYTE_W-1:0];
            VW_HI8: new_word[HALF_W-1:BYTE_W] = wdata[BYTE_W-1:0];
            VW_W16: new_word[HALF_W-1:0]      = wdata[HALF_W-1:0];
            VW_W32: new_word                  = wdata;
            default: new_word                 = old_word;
        endcase
    end
endmodule

// File: rtl/gpr_view_file.sv
module gpr_view_file
    import gprv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CODE_W   = 3,
    localparam int NUM_REG = 1 << CODE_W,
    localparam int NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op32,
    input  logic [CODE_W-1:0] rd0_code,
    input  logic              rd0_has_w,
    input  logic              rd0_w,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [CODE_W-1:0] rd1_code,
    input  logic              rd1_has_w,
    input  logic              rd1_w,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_has_w,
    input  logic              wr_w,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] regs [NUM_REG];

    // ---------------- write path ----------------
    logic [CODE_W-1:0] wr_idx;
    view_e             wr_view;
    logic [DATA_W-1:0] wr_old;
    logic [DATA_W-1:0] wr_new;

    gprv_decode #(.CODE_W(CODE_W)) u_wdec (
        .code (wr_code),
        .has_w(wr_has_w),
        .w    (wr_w),
        .op32 (op32),
        .idx  (wr_idx),
        .view (wr_view)
    );

    assign wr_old = regs[wr_idx];

    gprv_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word(wr_old),
        .wdata   (wr_data),
        .view    (wr_view),
        .new_word(wr_new)
    );

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == CODE_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (hit) begin
                regs[g] <= wr_new;
            end
        end
    end

    // ---------------- read paths ----------------
    logic [CODE_W-1:0] rd_code  [NUM_RD];
    logic              rd_has_w [NUM_RD];
    logic              rd_w     [NUM_RD];
    logic [DATA_W-1:0] rd_out   [NUM_RD];

    assign rd_code[0]  = rd0_code;
    assign rd_has_w[0] = rd0_has_w;
    assign rd_w[0]     = rd0_w;
    assign rd_code[1]  = rd1_code;
    assign rd_has_w[1] = rd1_has_w;
    assign rd_w[1]     = rd1_w;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic [CODE_W-1:0] idx;
        view_e             view;
        logic [DATA_W-1:0] word;

        gprv_decode #(.CODE_W(CODE_W)) u_dec (
            .code (rd_code[p]),
            .has_w(rd_has_w[p]),
            .w    (rd_w[p]),
            .op32 (op32),
            .idx  (idx),
            .view (view)
        );

        assign word = regs[idx];

        gprv_extract #(.DATA_W(DATA_W)) u_ext (
            .word(word),
            .view(view),
            .data(rd_out[p])
        );
    end

    assign rd0_data = rd_out[0];
    assign rd1_data = rd_out[1];
endmodule

// File: rtl/gpr_view_chk.sv
module gpr_view_chk #(
    parameter int DATA_W = 32,
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op32,
    input logic [CODE_W-1:0] rd0_code,
    input logic              rd0_has_w,
    input logic              rd0_w,
    input logic [DATA_W-1:0] rd0_data,
    input logic [CODE_W-1:0] rd1_code,
    input logic              rd1_has_w,
    input logic              rd1_w,
    input logic [DATA_W-1:0] rd1_data,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_code,
    input logic              wr_has_w,
    input logic              wr_w,
    input logic [DATA_W-1:0] wr_data
);
    function automatic logic [DATA_W-1:0] view_mask(logic hw, logic w, logic o32);
        if (hw && !w) return DATA_W'(8'hFF);
        if (!o32)     return DATA_W'(16'hFFFF);
        return '1;
    endfunction

    AST_RD0_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_has_w && !rd0_w) |-> (rd0_data[DATA_W-1:8] == '0)); // R7
    AST_RD1_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_has_w && !rd1_w) |-> (rd1_data[DATA_W-1:8] == '0)); // R7
    AST_RD0_WORD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd0_has_w || rd0_w) && !op32) |-> (rd0_data[DATA_W-1:16] == '0)); // R3
    AST_RD0_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_en) && $stable(rd0_code) && $stable(rd0_has_w) && $stable(rd0_w)
         && $stable(op32)) |-> $stable(rd0_data)); // R9
    AST_RD0_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && rd0_code == $past(wr_code) && rd0_has_w == $past(wr_has_w)
         && rd0_w == $past(wr_w) && op32 == $past(op32))
        |-> (rd0_data == ($past(wr_data) & view_mask(rd0_has_w, rd0_w, op32)))); // R8
endmodule

bind gpr_view_file gpr_view_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op32(op32),
    .rd0_code(rd0_code), .rd0_has_w(rd0_has_w), .rd0_w(rd0_w), .rd0_data(rd0_data),
    .rd1_code(rd1_code), .rd1_has_w(rd1_has_w), .rd1_w(rd1_w), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_code(wr_code), .wr_has_w(wr_has_w), .wr_w(wr_w), .wr_data(wr_data)
);

// File: tb/sim_gpr_view_file.sv
module sim_gpr_view_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op32 = 1'b0;
    logic [2:0]  rd0_code = '0, rd1_code = '0, wr_code = '0;
    logic        rd0_has_w = 1'b0, rd0_w = 1'b0, rd1_has_w = 1'b0, rd1_w = 1'b0;
    logic        wr_en = 1'b0, wr_has_w = 1'b0, wr_w = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd0_data, rd1_data;

    int total = 0;
    int bad = 0;
    logic [31:0] model [8];

    always #5 clk = ~clk;

    gpr_view_file u0 (
        .clk(clk), .rst_n(rst_n), .op32(op32),
        .rd0_code(rd0_code), .rd0_has_w(rd0_has_w), .rd0_w(rd0_w), .rd0_data(rd0_data),
        .rd1_code(rd1_code), .rd1_has_w(rd1_has_w), .rd1_w(rd1_w), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_code(wr_code), .wr_has_w(wr_has_w), .wr_w(wr_w), .wr_data(wr_data)
    );

    function automatic logic [31:0] m_read(logic [2:0] c, logic hw, logic w, logic o32);
        logic [31:0] r;
        if (hw && !w) begin
            r = model[{1'b0, c[1:0]}];
            return c[2] ? {24'b0, r[15:8]} : {24'b0, r[7:0]};
        end
        return o32 ? model[c] : {16'b0, model[c][15:0]};
    endfunction

    task automatic m_write(logic [2:0] c, logic hw, logic w, logic o32, logic [31:0] d);
        if (hw && !w) begin
            if (c[2]) model[{1'b0, c[1:0]}][15:8] = d[7:0];
            else      model[{1'b0, c[1:0]}][7:0]  = d[7:0];
        end else if (o32) model[c] = d;
        else model[c][15:0] = d[15:0];
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] c, logic hw, logic w, logic o32, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_code = c; wr_has_w = hw; wr_w = w; op32 = o32; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        m_write(c, hw, w, o32, d);
    endtask

    task automatic rd0(string req, logic [2:0] c, logic hw, logic w, logic o32);
        @(negedge clk);
        rd0_code = c; rd0_has_w = hw; rd0_w = w; op32 = o32;
        #1 chk(req, rd0_data, m_read(c, hw, w, o32));
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) model[i] = '0;
        @(negedge clk);
        rd0_code = 3'd5; rd0_has_w = 1'b0; op32 = 1'b1;
        rd1_code = 3'd2; rd1_has_w = 1'b1; rd1_w = 1'b0;
        #1;
        chk("R1 in reset rd0", rd0_data, 32'h0);
        chk("R1 in reset rd1", rd1_data, 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) rd0("R1 after reset", 3'(c), 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_fill_dword();
        for (int c = 0; c < 8; c++) wr(3'(c), 1'b0, 1'b0, 1'b1, 32'hA0B0C0D0 + 32'h01010101 * c);
        for (int c = 0; c < 8; c++) rd0("R2 dword index", 3'(c), 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_word_views();
        rd0("R3 no-w 16-bit view", 3'd6, 1'b0, 1'b0, 1'b0);
        rd0("R6 w=1 16-bit view", 3'd7, 1'b1, 1'b1, 1'b0);
        wr(3'd4, 1'b0, 1'b0, 1'b0, 32'hFFFF_1234);
        rd0("R8 word write keeps upper", 3'd4, 1'b0, 1'b0, 1'b1);
        wr(3'd5, 1'b1, 1'b1, 1'b0, 32'h0000_BEEF);
        rd0("R6 w=1 16-bit write", 3'd5, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_bytes();
        wr(3'd1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FF5A);
        rd0("R4 low byte readback", 3'd1, 1'b1, 1'b0, 1'b1);
        rd0("R8 low byte keeps rest", 3'd1, 1'b0, 1'b0, 1'b1);
        wr(3'd6, 1'b1, 1'b0, 1'b1, 32'h0000_00C3);
        rd0("R5 high byte readback", 3'd6, 1'b1, 1'b0, 1'b0);
        rd0("R5 high byte lands in reg2", 3'd2, 1'b0, 1'b0, 1'b1);
        rd0("R5 reg6 untouched", 3'd6, 1'b0, 1'b0, 1'b1);
        wr(3'd4, 1'b1, 1'b0, 1'b0, 32'h0000_0099);
        rd0("R5 reg0 high byte", 3'd0, 1'b0, 1'b0, 1'b1);
        rd0("R5 reg4 untouched", 3'd4, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_no_enable();
        @(negedge clk);
        wr_en = 1'b0; wr_code = 3'd3; wr_has_w = 1'b0; op32 = 1'b1; wr_data = 32'hDEAD_DEAD;
        @(posedge clk);
        rd0("R9 no write without enable", 3'd3, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1'b1; wr_code = 3'd7; wr_has_w = 1'b0; op32 = 1'b1; wr_data = 32'h1357_9BDF;
        rd0_code = 3'd7; rd0_has_w = 1'b0;
        #1 chk("R10 old value before edge", rd0_data, model[7]);
        @(posedge clk);
        #1 wr_en = 1'b0;
        m_write(3'd7, 1'b0, 1'b0, 1'b1, 32'h1357_9BDF);
        chk("R10 new value after edge", rd0_data, 32'h1357_9BDF);
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 2; o++)
            for (int m = 0; m < 3; m++)
                for (int c = 0; c < 8; c++) begin
                    @(negedge clk);
                    op32 = o[0];
                    rd0_code = 3'(c); rd0_has_w = (m != 0); rd0_w = (m == 2);
                    rd1_code = 3'(7 - c); rd1_has_w = (m != 2); rd1_w = (m == 0);
                    #1;
                    chk("R7 R11 sweep rd0", rd0_data, m_read(3'(c), m != 0, m == 2, o[0]));
                    chk("R7 R11 sweep rd1", rd1_data, m_read(3'(7 - c), m != 2, m == 0, o[0]));
                end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired got=hang exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_fill_dword();
        t_word_views();
        t_bytes();
        t_no_enable();
        t_same_cycle();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule